// File: doc/BRIEF.md
# Frame-Timed ADC Conversion Sequencer

This block runs one analog-to-digital conversion at a time on behalf of a host that reaches it through two registers. The host writes a control word carrying an enable bit, a channel number, a sync-enable bit and a start bit. It then polls a data word that holds the result and a valid flag. Each clock cycle is one serial-interface clock period.

A conversion first lets the selected input settle. The channel is then held and converted. Enabling the block starts a reference warm-up that must finish before the first settle phase. When sync mode is chosen, the block waits after settling for a rising edge on an external trigger pin, and only then holds the input. Completion sets the valid flag and gives a one-cycle event for an interrupt edge detector. The converter is a track-and-hold stub that samples a per-channel input level.

Top module: `adc_seq_top`

## Requirements
- R1: After reset the data word reads zero (valid flag in bit 15 clear, result in bits 9:0 zero) and irq_o is low.
- R2: A control write with the enable bit (bit 0) clear never starts a conversion, even with the start bit (bit 5) set.
- R3: A control write with enable set and start clear starts no conversion and leaves the data word unchanged.
- R4: After enable is set, no settle phase begins until STARTUP_CYC cycles have passed. A start written on the cycle after the enabling write gives valid exactly STARTUP_CYC+SEL_CYC+CONV_CYC cycles after the start write's clock edge.
- R5: With the reference warm and sync off, valid is clear for the first SEL_CYC+CONV_CYC-1 cycles after the start edge and is set exactly SEL_CYC+CONV_CYC cycles after it. This is within two 128-cycle frames.
- R6: The result is the level of the channel in control bits 3:1, sampled at the end of the settle phase. A change of that level during settling is seen. A change during conversion is not.
- R7: With sync enable (bit 4) set, the block waits after settling for a rising edge on sync_i. Valid follows SYNC_STAGES+CONV_CYC cycles after the first edge that samples sync_i high. A pin that was already high before the wait began does not trigger the conversion.
- R8: irq_o is high for exactly one cycle per completed conversion, in the cycle valid first reads set.
- R9: A control write with enable clear aborts any conversion, clears valid, raises no event for it, and forces a new warm-up before the next conversion.
- R10: A start written while a conversion is in progress is ignored. The running conversion completes at its original time with its original channel.
- R11: A start accepted while idle clears valid in the next cycle and restarts the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial-interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 6 | Control word: bit 0 enable, bits 3:1 channel, bit 4 sync enable, bit 5 start |
| sync_i | input | 1 | External conversion trigger, asynchronous |
| ain_i | input | NUM_CH*RES_W (80) | Analog levels of all channels, channel n at bits n*RES_W upward |
| data_o | output | 16 | Data word: bits 9:0 result, bit 15 valid |
| irq_o | output | 1 | One-cycle conversion-complete event |

## Verification
The hardest case to reach is a sync-mode conversion whose trigger pin rises during the settle phase and stays high. The block must then sit in its wait state and ignore the level until a fresh edge arrives. The stimulus raises the pin ten cycles into settling and holds it for hundreds of cycles while confirming that no result appears. It then drops and re-raises the pin, and the scoreboard expects completion at an exact cycle measured from that second edge. A second hard case is a start written in the middle of a conversion with a different channel. The scoreboard catches it through both the completion cycle and the returned level.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REF,
    ST_SETTLE,
    ST_SYNC,
    ST_CONV
  } seq_state_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/adc_seq_warmup.sv
module adc_seq_warmup #(
  parameter int STARTUP_CYC = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic ready_o
);
  localparam int CW = (STARTUP_CYC > 0) ? $clog2(STARTUP_CYC + 1) : 1;
  localparam logic [CW-1:0] LIMIT = CW'(STARTUP_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!en_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ready_o = en_i && (cnt_q == LIMIT);
endmodule

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic rise_o
);
  logic [STAGES-1:0] s_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q    <= '0;
      prev_q <= 1'b0;
    end else begin
      s_q[0] <= sync_i;
      for (int i = 1; i < STAGES; i++) s_q[i] <= s_q[i-1];
      prev_q <= s_q[STAGES-1];
    end
  end

  assign rise_o = s_q[STAGES-1] && !prev_q;
endmodule

// File: rtl/adc_seq_stub.sv
module adc_seq_stub #(
  parameter int NUM_CH = 8,
  parameter int RES_W  = 10,
  parameter int CH_W   = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_CH*RES_W-1:0] ain_i,
  input  logic [CH_W-1:0]         ch_i,
  input  logic                    capture_i,
  output logic [RES_W-1:0]        sample_o
);
  logic [RES_W-1:0] lvl [NUM_CH];
  logic [RES_W-1:0] hold_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign lvl[g] = ain_i[g*RES_W +: RES_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hold_q <= '0;
    else if (capture_i) hold_q <= (int'(ch_i) < NUM_CH) ? lvl[ch_i] : '0;
  end

  assign sample_o = hold_q;
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int CH_W     = 3,
  parameter int SEL_CYC  = 51,
  parameter int CONV_CYC = 102
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            abort_i,
  input  logic [CH_W-1:0] ch_i,
  input  logic            sync_en_i,
  input  logic            warm_ready_i,
  input  logic            sync_rise_i,
  output logic [CH_W-1:0] ch_o,
  output logic            capture_o,
  output logic            done_o,
  output logic            valid_o,
  output logic            irq_o,
  output seq_state_e      state_o
);
  localparam int CNT_W = $clog2(max_int(SEL_CYC, CONV_CYC) + 1);
  localparam logic [CNT_W-1:0] SEL_LOAD  = CNT_W'(SEL_CYC - 1);
  localparam logic [CNT_W-1:0] CONV_LOAD = CNT_W'(CONV_CYC - 1);

  seq_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CH_W-1:0] ch_q;
  logic            syn_q, valid_q, irq_q;
  logic            cnt_zero, busy;

  assign cnt_zero = (cnt_q == '0);
  assign busy     = (state_q != ST_IDLE);

  always_comb begin
    capture_o = 1'b0;
    if (!abort_i) begin
      if (state_q == ST_SETTLE && cnt_zero && !syn_q) capture_o = 1'b1;
      if (state_q == ST_SYNC && sync_rise_i)          capture_o = 1'b1;
    end
  end

  assign done_o = !abort_i && state_q == ST_CONV && cnt_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ch_q    <= '0;
      syn_q   <= 1'b0;
      valid_q <= 1'b0;
      irq_q   <= 1'b0;
    end else if (abort_i) begin
      state_q <= ST_IDLE;
      valid_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          ch_q    <= ch_i;
          syn_q   <= sync_en_i;
          valid_q <= 1'b0;
          if (warm_ready_i) begin
            state_q <= ST_SETTLE;
            cnt_q   <= SEL_LOAD;
          end else begin
            state_q <= ST_REF;
          end
        end
        ST_REF: if (warm_ready_i) begin
          state_q <= ST_SETTLE;
          cnt_q   <= SEL_LOAD;
        end
        ST_SETTLE: begin
          if (!cnt_zero) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (syn_q) begin
            state_q <= ST_SYNC;
          end else begin
            state_q <= ST_CONV;
            cnt_q   <= CONV_LOAD;
          end
        end
        ST_SYNC: if (sync_rise_i) begin
          state_q <= ST_CONV;
          cnt_q   <= CONV_LOAD;
        end
        ST_CONV: begin
          if (!cnt_zero) begin
            cnt_q <= cnt_q - 1'b1;
          end else begin
            state_q <= ST_IDLE;
            valid_q <= 1'b1;
            irq_q   <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ch_o    = ch_q;
  assign valid_o = valid_q;
  assign irq_o   = irq_q;
  assign state_o = state_q;

  p_irq_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
  p_valid_with_irq_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> irq_q);
  p_abort_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (state_q == ST_IDLE && !valid_q && !irq_q));
  p_busy_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && start_i && !abort_i) |=> $stable(ch_q));
  p_start_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && start_i && !abort_i) |=> (!valid_q && state_q != ST_IDLE));
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int RES_W       = 10,
  parameter int STARTUP_CYC = 60,
  parameter int SEL_CYC     = 51,
  parameter int CONV_CYC    = 102,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ctrl_we_i,
  input  logic [5:0]              ctrl_wdata_i,
  input  logic                    sync_i,
  input  logic [NUM_CH*RES_W-1:0] ain_i,
  output logic [DATA_W-1:0]       data_o,
  output logic                    irq_o
);
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int EN_POS    = 0;
  localparam int CH_POS    = 1;
  localparam int SYNC_POS  = CH_POS + CH_W;
  localparam int START_POS = SYNC_POS + 1;
  localparam int VALID_POS = DATA_W - 1;

  logic            en_q, warm_ready, sync_rise, capture, done, valid;
  logic            start_req, abort_req;
  logic [CH_W-1:0] ch_run;
  logic [RES_W-1:0] sample, result_q;
  seq_state_e      state;

  assign start_req = ctrl_we_i && ctrl_wdata_i[EN_POS] && ctrl_wdata_i[START_POS];
  assign abort_req = ctrl_we_i && !ctrl_wdata_i[EN_POS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_q <= 1'b0;
    else if (ctrl_we_i) en_q <= ctrl_wdata_i[EN_POS];
  end

  adc_seq_warmup #(.STARTUP_CYC(STARTUP_CYC)) u_warm (
    .clk_i, .rst_ni, .en_i(en_q), .ready_o(warm_ready)
  );

  adc_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sync_i, .rise_o(sync_rise)
  );

  adc_seq_fsm #(.CH_W(CH_W), .SEL_CYC(SEL_CYC), .CONV_CYC(CONV_CYC)) u_fsm (
    .clk_i, .rst_ni,
    .start_i     (start_req),
    .abort_i     (abort_req),
    .ch_i        (ctrl_wdata_i[CH_POS +: CH_W]),
    .sync_en_i   (ctrl_wdata_i[SYNC_POS]),
    .warm_ready_i(warm_ready),
    .sync_rise_i (sync_rise),
    .ch_o        (ch_run),
    .capture_o   (capture),
    .done_o      (done),
    .valid_o     (valid),
    .irq_o       (irq_o),
    .state_o     (state)
  );

  adc_seq_stub #(.NUM_CH(NUM_CH), .RES_W(RES_W), .CH_W(CH_W)) u_stub (
    .clk_i, .rst_ni, .ain_i, .ch_i(ch_run), .capture_i(capture), .sample_o(sample)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   result_q <= '0;
    else if (done) result_q <= sample;
  end

  always_comb begin
    data_o                 = '0;
    data_o[RES_W-1:0]      = result_q;
    data_o[VALID_POS]      = valid;
  end

  p_settle_after_ready_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != ST_IDLE && state != ST_REF) |-> warm_ready);
  p_disabled_no_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && state == ST_IDLE && !start_req) |=> state == ST_IDLE);
endmodule

// File: tb/tb_adc_seq_top.sv
module tb_adc_seq_top;
  localparam int NUM_CH = 8;
  localparam int RES_W  = 10;
  localparam int STARTUP = 60;
  localparam int SEL = 51;
  localparam int CONV = 102;
  localparam int SYNC_ST = 2;

  typedef struct {
    logic [RES_W-1:0] val;
    int               cyc;
    string            tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_we = 1'b0;
  logic [5:0] ctrl_wdata = '0;
  logic sync_pin = 1'b0;
  logic [RES_W-1:0] ain [NUM_CH];
  logic [NUM_CH*RES_W-1:0] ain_flat;
  logic [15:0] data;
  logic irq;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  exp_t sb_q[$];
  bit irq_prev = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ain
    assign ain_flat[g*RES_W +: RES_W] = ain[g];
  end

  adc_seq_top dut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .sync_i(sync_pin), .ain_i(ain_flat), .data_o(data), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] cw(input bit en, input int ch, input bit sy, input bit st);
    return {st, sy, 3'(ch), en};
  endfunction

  task automatic wr(input logic [5:0] v, output int c0);
    @(negedge clk);
    c0 = cyc;
    ctrl_we = 1'b1;
    ctrl_wdata = v;
    @(posedge clk);
    #1 ctrl_we = 1'b0;
  endtask

  task automatic push_exp(input logic [RES_W-1:0] v, input int c, input string tag);
    exp_t e;
    e.val = v; e.cyc = c; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic drain();
    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_prev) chk(!irq, "R8", "irq width", int'(irq), 0);
      if (irq) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R8", "unexpected irq", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(data[9:0] == e.val, e.tag, "result", int'(data[9:0]), int'(e.val));
          chk(cyc == e.cyc, e.tag, "completion cycle", cyc, e.cyc);
          chk(data[15], "R8", "valid with irq", int'(data[15]), 1);
        end
      end
      irq_prev = irq;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "WATCHDOG", "timeout", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int c0, c1, c2;
    for (int i = 0; i < NUM_CH; i++) ain[i] = RES_W'(100 + 37 * i);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(data == 16'h0, "R1", "data after reset", int'(data), 0);
    chk(!irq, "R1", "irq after reset", int'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 start with enable clear
    wr(cw(0, 2, 0, 1), c0);
    repeat (300) @(negedge clk);
    chk(!data[15], "R2", "valid while disabled", int'(data[15]), 0);

    // R4 start right after enable
    wr(cw(1, 2, 0, 0), c0);
    wr(cw(1, 2, 0, 1), c1);
    push_exp(ain[2], c1 + 1 + STARTUP + SEL + CONV, "R4");
    drain();

    // R3 write without start
    ain[3] = 10'd777;
    wr(cw(1, 3, 0, 0), c0);
    repeat (300) @(negedge clk);
    chk(data == {1'b1, 5'b0, ain[2]}, "R3", "data after non-start write", int'(data), int'({1'b1, 5'b0, ain[2]}));

    // R5/R6 warm start, level changes in settle and in conversion
    ain[4] = 10'd11;
    wr(cw(1, 4, 0, 1), c0);
    push_exp(10'd222, c0 + 1 + SEL + CONV, "R6");
    repeat (20) @(negedge clk);
    ain[4] = 10'd222;
    repeat (50) @(negedge clk);
    ain[4] = 10'd333;
    while (cyc < c0 + SEL + CONV) @(negedge clk);
    chk(!data[15], "R5", "valid one cycle early", int'(data[15]), 0);
    chk(SEL + CONV <= 256, "R5", "two-frame bound", SEL + CONV, 256);
    drain();

    // R10/R11 busy start ignored, idle start clears valid
    ain[5] = 10'd505; ain[6] = 10'd606;
    wr(cw(1, 5, 0, 1), c0);
    push_exp(10'd505, c0 + 1 + SEL + CONV, "R10");
    @(negedge clk);
    chk(!data[15], "R11", "valid after start", int'(data[15]), 0);
    repeat (30) @(negedge clk);
    wr(cw(1, 6, 0, 1), c1);
    drain();

    // R7 sync mode
    ain[1] = 10'd901;
    wr(cw(1, 1, 1, 1), c0);
    repeat (400) @(negedge clk);
    chk(!data[15], "R7", "valid while waiting for sync", int'(data[15]), 0);
    c2 = cyc;
    sync_pin = 1'b1;
    push_exp(10'd901, c2 + 1 + SYNC_ST + CONV, "R7");
    drain();
    sync_pin = 1'b0;
    repeat (5) @(negedge clk);

    // R7 corner: pin already high before the wait
    ain[1] = 10'd123;
    wr(cw(1, 1, 1, 1), c0);
    repeat (10) @(negedge clk);
    sync_pin = 1'b1;
    repeat (300) @(negedge clk);
    chk(!data[15], "R7", "stale high level triggered", int'(data[15]), 0);
    sync_pin = 1'b0;
    repeat (5) @(negedge clk);
    c2 = cyc;
    sync_pin = 1'b1;
    push_exp(10'd123, c2 + 1 + SYNC_ST + CONV, "R7");
    drain();
    sync_pin = 1'b0;

    // R9 abort
    chk(data[15], "R9", "valid before disable", int'(data[15]), 1);
    wr(cw(0, 1, 0, 0), c0);
    @(negedge clk);
    chk(!data[15], "R9", "valid after disable", int'(data[15]), 0);
    wr(cw(1, 2, 0, 0), c0);
    wr(cw(1, 2, 0, 1), c1);
    repeat (150) @(negedge clk);
    wr(cw(0, 2, 0, 0), c0);
    repeat (300) @(negedge clk);
    chk(!data[15], "R9", "valid after mid-conversion abort", int'(data[15]), 0);
    ain[2] = 10'd444;
    wr(cw(1, 2, 0, 0), c0);
    wr(cw(1, 2, 0, 1), c1);
    push_exp(10'd444, c1 + 1 + STARTUP + SEL + CONV, "R9");
    drain();

    chk(sb_q.size() == 0, "R8", "pending expectations", sb_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule